// File: doc/BRIEF.md
# Daisy-Chain Input Serializer Reader

This block is an SPI master that collects the state of a chain of industrial input serializer chips in a single chip-select frame. Every chip in the chain gives 8 input bits. In wide mode, each chip also sends a status byte after its data byte. The block checks a 5-bit CRC carried in each status byte. It decodes the over-temperature and undervoltage indications and merges them with a fault pin, which is either one line shared by the chain or one line per chip. The result is a separate fault flag for every chip.

A host pulses `start_i`. The block then clocks the whole chain and pulses `done_o` for one cycle. At that pulse it refreshes the input bitmap and all per-chip diagnostic bitmaps together. Faults are tracked per chip, so the inputs of healthy chips stay usable when another chip in the chain reports a problem.

Top module: `chain_reader`

## Requirements
- R1: An accepted `start_i` drives `spi_cs_no` low. The frame then gives exactly N_CHIPS*8 rising SCLK edges in narrow mode (`wide_i`=0) or N_CHIPS*16 in wide mode (`wide_i`=1). The mode and `ignore_uv_i` are captured when the start is accepted.
- R2: The first byte on the wire belongs to chip 0. Bytes arrive MSB first. `data_o[c*8+k]` is bit k of chip c's data byte. In wide mode the wire order per chip is data byte, then status byte.
- R3: In wide mode, `crc_err_o[c]` is set when the status byte ANDed with 0xF8 differs from the CRC of the data byte. The CRC is computed MSB first, from a zero start, with feedback byte 0xA8, over 8 bits.
- R4: In wide mode, `ot_o[c]` equals status bit 1 (1 = over-temperature).
- R5: In wide mode, `uv_alarm_o[c]` is set when status bit 2 is 0, and `uv_warn_o[c]` is set when status bit 0 is 0. The warning alone never sets `fault_o[c]`.
- R6: While the captured `ignore_uv_i` is 1, both undervoltage flags read 0 and the fault pins have no effect on `fault_o`.
- R7: With FAULT_LINES=1, the single pin applies to every chip. With FAULT_LINES=N_CHIPS, chip c uses `fault_pin_i[c]`. Pins are active high and are sampled at the end of the frame.
- R8: `fault_o[c]` = (pin of chip c and not ignore-uv) OR `crc_err_o[c]` OR `ot_o[c]` OR `uv_alarm_o[c]`. The bit depends only on chip c's own diagnostics.
- R9: In narrow mode, `crc_err_o`, `ot_o`, `uv_alarm_o` and `uv_warn_o` read 0, and the fault pin is the only fault source.
- R10: `done_o` is a one-cycle pulse. All outputs change only in the cycle where `done_o` is 1. A `start_i` during a frame is ignored, including any mode change on `wide_i`.
- R11: The SPI interface uses mode 0. SCLK is low whenever chip select is high. Chip select stays low for the whole frame and rises once per frame, before `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a readout (ignored while busy) |
| wide_i | input | 1 | 1 = data+status per chip, 0 = data only |
| ignore_uv_i | input | 1 | Suppress undervoltage flags and fault pins |
| fault_pin_i | input | FAULT_LINES | Active-high fault lines from the chain |
| spi_sclk_o | output | 1 | SPI clock, idle low |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_miso_i | input | 1 | Serial data from the chain |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | N_CHIPS*8 | Captured input bits |
| crc_err_o | output | N_CHIPS | Per-chip CRC mismatch |
| ot_o | output | N_CHIPS | Per-chip over-temperature |
| uv_alarm_o | output | N_CHIPS | Per-chip undervoltage alarm |
| uv_warn_o | output | N_CHIPS | Per-chip undervoltage warning |
| fault_o | output | N_CHIPS | Per-chip combined fault |

## Verification
A wrong bit or byte counter shows first as a wrong count of SCLK edges between the chip-select edges. It then shows as inputs or status moved to the neighbouring chip in `data_o` and the flag bitmaps, visible at the next `done_o`. An error in the CRC or status decode corrupts only the flag bits of the affected chip, so the bench compares every bitmap per chip after every frame. A frame with a failed commit leaves stale outputs, and the bench also samples the outputs mid-frame to confirm that no partial update appears before the pulse.

// File: rtl/chain_reader_pkg.sv
package chain_reader_pkg;

  typedef enum logic {
    RX_IDLE,
    RX_SHIFT
  } rx_state_e;

  localparam logic [7:0] CRC_FEEDBACK = 8'hA8;

  // MSB-first CRC of one byte from a zero start; low 3 bits always end at 0
  function automatic logic [7:0] crc_of_byte(input logic [7:0] d);
    logic [7:0] r;
    r = d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ CRC_FEEDBACK) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/chain_spi_rx.sv
module chain_spi_rx
  import chain_reader_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int BIT_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BIT_W-1:0] nbits_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             busy_o,
  output logic [7:0]       byte_o,
  output logic             byte_v_o,
  output logic [BIT_W-4:0] byte_idx_o,
  output logic             frame_end_o
);

  localparam int CW = $clog2(CLK_DIV + 1);

  rx_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [BIT_W-1:0] bits_q, total_q;
  logic [6:0]       sh_q;
  logic             sclk_q, cs_n_q, byte_v_q, frame_end_q;
  logic [7:0]       byte_q;
  logic [BIT_W-4:0] idx_q;
  logic             tick;

  assign tick = (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      bits_q      <= '0;
      total_q     <= '0;
      sh_q        <= '0;
      sclk_q      <= 1'b0;
      cs_n_q      <= 1'b1;
      byte_v_q    <= 1'b0;
      byte_q      <= '0;
      idx_q       <= '0;
      frame_end_q <= 1'b0;
    end else begin
      byte_v_q    <= 1'b0;
      frame_end_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (start_i) begin
            state_q <= RX_SHIFT;
            cs_n_q  <= 1'b0;
            cnt_q   <= '0;
            bits_q  <= '0;
            sclk_q  <= 1'b0;
            total_q <= nbits_i;
          end
        end
        RX_SHIFT: begin
          if (tick) begin
            cnt_q <= '0;
            if (!sclk_q) begin
              // rising SCLK: sample the line (mode 0)
              sclk_q <= 1'b1;
              sh_q   <= {sh_q[5:0], miso_i};
              bits_q <= bits_q + 1'b1;
              if (bits_q[2:0] == 3'd7) begin
                byte_v_q <= 1'b1;
                byte_q   <= {sh_q, miso_i};
                idx_q    <= bits_q[BIT_W-1:3];
              end
            end else begin
              sclk_q <= 1'b0;
              if (bits_q == total_q) begin
                state_q     <= RX_IDLE;
                cs_n_q      <= 1'b1;
                frame_end_q <= 1'b1;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign sclk_o      = sclk_q;
  assign cs_no       = cs_n_q;
  assign busy_o      = (state_q != RX_IDLE);
  assign byte_o      = byte_q;
  assign byte_v_o    = byte_v_q;
  assign byte_idx_o  = idx_q;
  assign frame_end_o = frame_end_q;

  p_sclk_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sclk_q);

  p_frame_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_q) |-> (bits_q == total_q));

  p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_SHIFT && start_i) |=> $stable(total_q));

endmodule

// File: rtl/chain_byte_store.sv
module chain_byte_store #(
  parameter int N_CHIPS = 3,
  parameter int IW      = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wide_i,
  input  logic                    byte_v_i,
  input  logic [7:0]              byte_i,
  input  logic [IW-1:0]           idx_i,
  output logic [N_CHIPS-1:0][7:0] data_o,
  output logic [N_CHIPS-1:0][7:0] stat_o
);

  for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip
    localparam logic [IW-1:0] WIDE_DATA = IW'(2 * c);
    localparam logic [IW-1:0] WIDE_STAT = IW'(2 * c + 1);
    localparam logic [IW-1:0] NARROW    = IW'(c);

    logic hit_data, hit_stat;
    assign hit_data = byte_v_i && (wide_i ? (idx_i == WIDE_DATA) : (idx_i == NARROW));
    assign hit_stat = byte_v_i && wide_i && (idx_i == WIDE_STAT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[c] <= '0;
        stat_o[c] <= '0;
      end else begin
        if (hit_data) data_o[c] <= byte_i;
        if (hit_stat) stat_o[c] <= byte_i;
      end
    end
  end

endmodule

// File: rtl/chain_chip_diag.sv
module chain_chip_diag
  import chain_reader_pkg::*;
(
  input  logic [7:0] data_i,
  input  logic [7:0] stat_i,
  input  logic       wide_i,
  input  logic       ign_i,
  input  logic       pin_i,
  output logic       crc_err_o,
  output logic       ot_o,
  output logic       uv_alarm_o,
  output logic       uv_warn_o,
  output logic       fault_o
);

  always_comb begin
    crc_err_o  = wide_i && ((stat_i & 8'hF8) != crc_of_byte(data_i));
    ot_o       = wide_i && stat_i[1];
    uv_alarm_o = wide_i && !ign_i && !stat_i[2];
    uv_warn_o  = wide_i && !ign_i && !stat_i[0];
    fault_o    = (pin_i && !ign_i) || crc_err_o || ot_o || uv_alarm_o;
  end

endmodule

// File: rtl/chain_reader.sv
module chain_reader
  import chain_reader_pkg::*;
#(
  parameter int N_CHIPS     = 3,
  parameter int CLK_DIV     = 2,
  parameter int FAULT_LINES = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   wide_i,
  input  logic                   ignore_uv_i,
  input  logic [FAULT_LINES-1:0] fault_pin_i,
  output logic                   spi_sclk_o,
  output logic                   spi_cs_no,
  input  logic                   spi_miso_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [N_CHIPS*8-1:0]   data_o,
  output logic [N_CHIPS-1:0]     crc_err_o,
  output logic [N_CHIPS-1:0]     ot_o,
  output logic [N_CHIPS-1:0]     uv_alarm_o,
  output logic [N_CHIPS-1:0]     uv_warn_o,
  output logic [N_CHIPS-1:0]     fault_o
);

  localparam int MAXB = N_CHIPS * 16;
  localparam int BW   = $clog2(MAXB + 1);
  localparam int IW   = BW - 3;

  logic                    wide_q, ign_q, accept;
  logic [BW-1:0]           nbits;
  logic [7:0]              rx_byte;
  logic                    rx_v, frame_end;
  logic [IW-1:0]           rx_idx;
  logic [N_CHIPS-1:0][7:0] data_sh, stat_sh;
  logic [N_CHIPS-1:0]      pin_sel, crc_c, ot_c, uva_c, uvw_c, flt_c;

  assign accept = start_i && !busy_o;
  assign nbits  = wide_i ? BW'(MAXB) : BW'(MAXB / 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b0;
      ign_q  <= 1'b0;
    end else if (accept) begin
      wide_q <= wide_i;
      ign_q  <= ignore_uv_i;
    end
  end

  chain_spi_rx #(.CLK_DIV(CLK_DIV), .BIT_W(BW)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .nbits_i     (nbits),
    .miso_i      (spi_miso_i),
    .sclk_o      (spi_sclk_o),
    .cs_no       (spi_cs_no),
    .busy_o      (busy_o),
    .byte_o      (rx_byte),
    .byte_v_o    (rx_v),
    .byte_idx_o  (rx_idx),
    .frame_end_o (frame_end)
  );

  chain_byte_store #(.N_CHIPS(N_CHIPS), .IW(IW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wide_i   (wide_q),
    .byte_v_i (rx_v),
    .byte_i   (rx_byte),
    .idx_i    (rx_idx),
    .data_o   (data_sh),
    .stat_o   (stat_sh)
  );

  for (genvar c = 0; c < N_CHIPS; c++) begin : g_diag
    if (FAULT_LINES == 1) begin : g_shared
      assign pin_sel[c] = fault_pin_i[0];
    end else begin : g_own
      assign pin_sel[c] = fault_pin_i[c];
    end

    chain_chip_diag u_diag (
      .data_i     (data_sh[c]),
      .stat_i     (stat_sh[c]),
      .wide_i     (wide_q),
      .ign_i      (ign_q),
      .pin_i      (pin_sel[c]),
      .crc_err_o  (crc_c[c]),
      .ot_o       (ot_c[c]),
      .uv_alarm_o (uva_c[c]),
      .uv_warn_o  (uvw_c[c]),
      .fault_o    (flt_c[c])
    );
  end

  // single commit point: no partial frame is ever visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      data_o     <= '0;
      crc_err_o  <= '0;
      ot_o       <= '0;
      uv_alarm_o <= '0;
      uv_warn_o  <= '0;
      fault_o    <= '0;
    end else begin
      done_o <= frame_end;
      if (frame_end) begin
        data_o     <= data_sh;
        crc_err_o  <= crc_c;
        ot_o       <= ot_c;
        uv_alarm_o <= uva_c;
        uv_warn_o  <= uvw_c;
        fault_o    <= flt_c;
      end
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(data_o) && $stable(fault_o) && $stable(crc_err_o)));

  p_narrow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_q) |-> (crc_err_o == '0 && ot_o == '0 && uv_alarm_o == '0 && uv_warn_o == '0));

  p_ignore_uv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ign_q) |-> (uv_alarm_o == '0 && uv_warn_o == '0));

  p_done_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (spi_cs_no && !busy_o));

endmodule

// File: tb/chain_reader_bench.sv
module chain_reader_bench;

  localparam int N   = 3;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wide = 1'b0, ign = 1'b0;
  logic [N-1:0] pins = '0;
  logic miso;
  logic sclk, cs_n, busy, done;
  logic [N*8-1:0] data;
  logic [N-1:0] crc_err, ot, uva, uvw, flt;
  logic sclk_s, cs_n_s, busy_s, done_s;
  logic [N*8-1:0] data_s;
  logic [N-1:0] crc_s, ot_s, uva_s, uvw_s, flt_s;

  int checks = 0, errors = 0, cycles = 0;
  int edges = 0, cs_rises = 0, idle_clk_bad = 0, bidx = 0;
  logic [7:0] tx [0:2*N-1];
  int nbits = 0;

  always #10 clk = ~clk;

  chain_reader #(.N_CHIPS(N), .CLK_DIV(DIV), .FAULT_LINES(N)) u_chain_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_i(wide), .ignore_uv_i(ign),
    .fault_pin_i(pins), .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_miso_i(miso),
    .busy_o(busy), .done_o(done), .data_o(data), .crc_err_o(crc_err), .ot_o(ot),
    .uv_alarm_o(uva), .uv_warn_o(uvw), .fault_o(flt));

  chain_reader #(.N_CHIPS(N), .CLK_DIV(DIV), .FAULT_LINES(1)) u_chain_reader_shared (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_i(wide), .ignore_uv_i(ign),
    .fault_pin_i(pins[0]), .spi_sclk_o(sclk_s), .spi_cs_no(cs_n_s), .spi_miso_i(miso),
    .busy_o(busy_s), .done_o(done_s), .data_o(data_s), .crc_err_o(crc_s), .ot_o(ot_s),
    .uv_alarm_o(uva_s), .uv_warn_o(uvw_s), .fault_o(flt_s));

  // chain model: bit 0 ready at CS fall, advances on SCLK fall
  always @(negedge cs_n) bidx = 0;
  always @(negedge sclk) if (!cs_n) bidx = bidx + 1;
  assign miso = (bidx < nbits) ? tx[bidx / 8][7 - (bidx % 8)] : 1'b0;

  always @(posedge sclk) if (!cs_n) edges++;
  always @(posedge cs_n) cs_rises++;
  always @(negedge clk) if (cs_n && sclk) idle_clk_bad++;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // serial LFSR form of the status CRC
  function automatic logic [7:0] ref_crc(input logic [7:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      logic fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'hA8;
    end
    return c;
  endfunction

  function automatic logic [7:0] good_st(input logic [7:0] d);
    return ref_crc(d) | 8'h05;
  endfunction

  task automatic frame(input logic w, input logic ig, input logic [N*8-1:0] dat,
                       input logic [N*8-1:0] st, input logic [N-1:0] p);
    logic [N*8-1:0] prev_d;
    logic [N-1:0] e_crc, e_ot, e_uva, e_uvw, e_flt, e_flt_s;
    int t = 0, r0;
    for (int c = 0; c < N; c++) begin
      if (w) begin
        tx[2*c] = dat[c*8 +: 8];
        tx[2*c+1] = st[c*8 +: 8];
      end else tx[c] = dat[c*8 +: 8];
    end
    nbits = w ? N * 16 : N * 8;
    for (int c = 0; c < N; c++) begin
      logic [7:0] s = st[c*8 +: 8];
      logic [7:0] d = dat[c*8 +: 8];
      e_crc[c] = w && ((s & 8'hF8) != ref_crc(d));
      e_ot[c]  = w && s[1];
      e_uva[c] = w && !ig && !s[2];
      e_uvw[c] = w && !ig && !s[0];
      e_flt[c] = (!ig && p[c]) || e_crc[c] || e_ot[c] || e_uva[c];
      e_flt_s[c] = (!ig && p[0]) || e_crc[c] || e_ot[c] || e_uva[c];
    end
    prev_d = data;
    edges = 0;
    r0 = cs_rises;
    @(negedge clk);
    wide = w; ign = ig; pins = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 no partial update mid-frame", data, prev_d);
    chk("R11 cs low during frame", cs_n, 0);
    start = 1'b1; wide = ~w; ign = ~ig;
    @(negedge clk);
    start = 1'b0; wide = w; ign = ig;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk("R10 done arrives", done, 1);
    chk("R1 sclk edge count", edges, nbits);
    chk("R11 one cs rise per frame", cs_rises - r0, 1);
    chk("R2 input bits", data, dat);
    chk("R3 crc error map", crc_err, e_crc);
    chk("R4 over-temp map", ot, e_ot);
    chk("R5 uv alarm map", uva, e_uva);
    chk("R5 uv warn map", uvw, e_uvw);
    chk("R8 per-chip fault map", flt, e_flt);
    chk("R7 shared-pin fault map", flt_s, e_flt_s);
    chk("R7 shared variant data", data_s, dat);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
    chk("R10 outputs held after done", data, dat);
  endtask

  initial begin
    logic [N*8-1:0] d, s;
    repeat (3) @(negedge clk);
    chk("R11 reset cs high", cs_n, 1);
    chk("R11 reset sclk low", sclk, 0);
    chk("R10 reset done low", done, 0);
    chk("R2 reset data", data, 0);
    chk("R8 reset fault", flt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 narrow mode, no pins
    frame(1'b0, 1'b0, 24'h813CA5, 24'h000000, 3'b000);
    // R7 R9 per-chip pin on chip 1 only; shared pin low
    frame(1'b0, 1'b0, 24'h5A0FF0, 24'h0, 3'b010);
    // R7 shared pin high flags every chip
    frame(1'b0, 1'b0, 24'h123456, 24'h0, 3'b001);
    // R6 narrow with ignore: pins have no effect
    frame(1'b0, 1'b1, 24'hFFFFFF, 24'h0, 3'b111);
    // R3 wide mode, all healthy
    d = 24'hC3_7E_01;
    s = {good_st(d[23:16]), good_st(d[15:8]), good_st(d[7:0])};
    frame(1'b1, 1'b0, d, s, 3'b000);
    // R3 R8 chip 1 bad CRC, others valid
    s[15:8] = s[15:8] ^ 8'h08;
    frame(1'b1, 1'b0, d, s, 3'b000);
    // R4 chip 2 over-temp
    s = {good_st(d[23:16]) | 8'h02, good_st(d[15:8]), good_st(d[7:0])};
    frame(1'b1, 1'b0, d, s, 3'b000);
    // R5 chip 0 warning only: no fault
    s = {good_st(d[23:16]), good_st(d[15:8]), good_st(d[7:0]) & 8'hFE};
    frame(1'b1, 1'b0, d, s, 3'b000);
    // R5 chip 1 undervoltage alarm
    s = {good_st(d[23:16]), good_st(d[15:8]) & 8'hFB, good_st(d[7:0])};
    frame(1'b1, 1'b0, d, s, 3'b100);
    // R6 same frame with ignore: flags and pin suppressed
    frame(1'b1, 1'b1, d, s, 3'b100);

    for (int k = 0; k < 40; k++) begin
      logic w = 1'($urandom);
      logic ig = ($urandom % 4) == 0;
      d = N*8'($urandom);
      for (int c = 0; c < N; c++) begin
        if (($urandom % 10) < 7) s[c*8 +: 8] = good_st(d[c*8 +: 8]) ^ 8'(($urandom % 8) & 3'b111);
        else s[c*8 +: 8] = 8'($urandom);
      end
      frame(w, ig, d, s, N'($urandom));
    end

    chk("R11 sclk never high with cs high", idle_clk_bad, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
  end

endmodule